// File: doc/BRIEF.md
# DSP Data Address Generator

This block forms the effective data address for every operand access of a 16-bit-word signal-processing core. The instruction path supplies a mode code and an offset. The register file supplies page, stack, I/O base and pointer values. The block returns either a 23-bit data address or a 16-bit I/O port address, and it does so in the same cycle.

Direct modes build the address from two parts. A 7-bit page field is placed above a 16-bit sum, and that sum wraps within its own 16 bits, so it never carries into the page. Pointer modes address through one of eight general pointers or a dedicated coefficient pointer. A pointer can be post-incremented, with optional circular wrap inside a buffer. Pointers 0 to 3 share one buffer start/size pair, pointers 4 to 7 share another, and the coefficient pointer has its own pair and its own page field.

The updated pointer value is not written inside the block. It is presented one clock later on a write-back port for the register file to store.

Top module: `dsp_agu`

## Requirements
- R1: With mode code 0 (absolute), `addr_o` equals `abs_addr_i` unchanged. Mode codes 6 and 7 give `addr_o` = 0 and no write-back.
- R2: With mode code 1 (paged), `addr_o` = {`dp_page_i`, (`dp_i` + `offset_i`) mod 2^16}. A carry out of the 16-bit sum never changes the page bits.
- R3: With mode code 2 (stack), `addr_o` = {`sp_page_i`, (`sp_i` + `offset_i`) mod 2^16}.
- R4: With mode code 3 (I/O), `io_addr_o` = {`io_base_i`[15:6], `offset_i`[5:0]}, `io_sel_o` = 1 and `addr_o` = 0. In every other mode `io_sel_o` = 0.
- R5: With mode code 4 (pointer), `addr_o` = {`ar_page_i`, pointer `ptr_sel_i`}. The pointer value used is the one before modification, and pointer k occupies bits [16k+15:16k] of `ar_i`.
- R6: With mode code 5 (coefficient), `addr_o` = {`coef_page_i`, `coef_ptr_i`}.
- R7: With post-increment and circular mode off, the written-back value is the pointer + 1 mod 2^16, so 0xFFFF becomes 0x0000.
- R8: With circular mode on, a pointer equal to the last buffer element (start + size − 1 mod 2^16) steps to the buffer start. Pointers 0–3 use `buf_start_i`/`buf_size_i` slot 0 (bits [15:0]), pointers 4–7 use slot 1 (bits [31:16]), and the coefficient pointer uses `coef_start_i`/`coef_size_i`.
- R9: A buffer size of zero disables the wrap, and the pointer then steps linearly.
- R10: When mode is 4 or 5 and `post_inc_i` = 1 at a rising edge, `wb_en_o` is 1 in the following cycle, with `wb_sel_o` = pointer index (mode 4) or 8 (mode 5) and `wb_val_o` = the new value. Otherwise `wb_en_o` is 0 in that cycle.
- R11: While `rst_n` is low, `wb_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Addressing mode code |
| offset_i | input | 16 | Offset from the instruction |
| abs_addr_i | input | 23 | Full address for absolute mode |
| dp_page_i | input | 7 | Page field for paged mode |
| dp_i | input | 16 | Data page base |
| sp_page_i | input | 7 | Page field for stack mode |
| sp_i | input | 16 | Stack pointer |
| io_base_i | input | 16 | I/O base; bits [15:6] used |
| ar_page_i | input | 7 | Page field for general pointers |
| ar_i | input | 128 | Eight 16-bit general pointers |
| ptr_sel_i | input | 3 | General pointer index |
| coef_page_i | input | 7 | Page field for coefficient pointer |
| coef_ptr_i | input | 16 | Coefficient pointer |
| post_inc_i | input | 1 | Post-modify enable |
| circ_en_i | input | 1 | Circular wrap enable |
| buf_start_i | input | 32 | Buffer start per pointer group |
| buf_size_i | input | 32 | Buffer size per pointer group |
| coef_start_i | input | 16 | Coefficient buffer start |
| coef_size_i | input | 16 | Coefficient buffer size |
| addr_o | output | 23 | Data address |
| io_addr_o | output | 16 | I/O port address |
| io_sel_o | output | 1 | I/O access flag |
| wb_en_o | output | 1 | Pointer write-back strobe |
| wb_sel_o | output | 4 | Write-back target (0–7 pointer, 8 coefficient) |
| wb_val_o | output | 16 | Write-back value |

## Verification
A new address is issued combinationally in the same cycle that the registered write-back of the previous access appears. The two therefore collide whenever pointer accesses run back to back. The bench chains post-incremented accesses on consecutive cycles, each one starting from the value just written back. In each cycle it checks the current `addr_o` together with the previous `wb_*` outputs, including the steps where a wrap occurs and the steps where the pointer group, and with it the buffer pair, changes.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [2:0] {
      AM_ABS   = 3'd0,
      AM_PAGE  = 3'd1,
      AM_STACK = 3'd2,
      AM_IO    = 3'd3,
      AM_PTR   = 3'd4,
      AM_COEF  = 3'd5
   } agu_mode_e;

   function automatic logic is_ptr_mode(input logic [2:0] m);
      return (m == AM_PTR) || (m == AM_COEF);
   endfunction
endpackage

// File: rtl/agu_direct.sv
module agu_direct
   import agu_pkg::*;
#(
   parameter int PAGE_W   = 7,
   parameter int OFS_W    = 16,
   parameter int IO_LOW_W = 6,
   localparam int DADDR_W = PAGE_W + OFS_W
) (
   input  logic [2:0]         mode,
   input  logic [OFS_W-1:0]   offset,
   input  logic [DADDR_W-1:0] abs_addr,
   input  logic [PAGE_W-1:0]  dp_page,
   input  logic [OFS_W-1:0]   dp,
   input  logic [PAGE_W-1:0]  sp_page,
   input  logic [OFS_W-1:0]   sp,
   input  logic [OFS_W-1:0]   io_base,
   output logic [DADDR_W-1:0] dir_addr,
   output logic [OFS_W-1:0]   io_addr,
   output logic               io_sel
);
   logic [OFS_W-1:0] dp_sum;
   logic [OFS_W-1:0] sp_sum;

   // 16-bit sums: carry dropped, page field concatenated above
   assign dp_sum = dp + offset;
   assign sp_sum = sp + offset;

   assign io_addr = {io_base[OFS_W-1:IO_LOW_W], offset[IO_LOW_W-1:0]};
   assign io_sel  = (mode == AM_IO);

   always_comb begin
      unique case (mode)
         AM_ABS:   dir_addr = abs_addr;
         AM_PAGE:  dir_addr = {dp_page, dp_sum};
         AM_STACK: dir_addr = {sp_page, sp_sum};
         default:  dir_addr = '0;
      endcase
   end
endmodule

// File: rtl/agu_ptr_step.sv
module agu_ptr_step #(
   parameter int OFS_W        = 16,
   parameter bit CIRC_SUPPORT = 1'b1
) (
   input  logic [OFS_W-1:0] ptr,
   input  logic [OFS_W-1:0] start,
   input  logic [OFS_W-1:0] size,
   input  logic             circ_en,
   output logic [OFS_W-1:0] nxt
);
   logic [OFS_W-1:0] lin;
   assign lin = ptr + OFS_W'(1);

   generate
      if (CIRC_SUPPORT) begin : g_circ
         logic [OFS_W-1:0] last;
         logic             wrap;
         assign last = start + size - OFS_W'(1);
         assign wrap = circ_en && (size != '0) && (ptr == last);
         assign nxt  = wrap ? start : lin;
      end else begin : g_lin
         logic unused_ok;
         assign unused_ok = ^{start, size, circ_en};
         assign nxt = lin;
      end
   endgenerate
endmodule

// File: rtl/agu_wb_reg.sv
module agu_wb_reg #(
   parameter int SEL_W = 4,
   parameter int OFS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_en,
   input  logic [SEL_W-1:0] upd_sel,
   input  logic [OFS_W-1:0] upd_val,
   output logic             wb_en,
   output logic [SEL_W-1:0] wb_sel,
   output logic [OFS_W-1:0] wb_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_en  <= 1'b0;
         wb_sel <= '0;
         wb_val <= '0;
      end else begin
         wb_en <= upd_en;
         if (upd_en) begin
            wb_sel <= upd_sel;
            wb_val <= upd_val;
         end
      end
   end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
   import agu_pkg::*;
#(
   parameter int PAGE_W       = 7,
   parameter int OFS_W        = 16,
   parameter int IO_LOW_W     = 6,
   parameter int NUM_PTR      = 8,
   parameter int GROUP_SZ     = 4,
   parameter bit CIRC_SUPPORT = 1'b1,
   localparam int DADDR_W   = PAGE_W + OFS_W,
   localparam int NGRP      = NUM_PTR / GROUP_SZ,
   localparam int SEL_W     = $clog2(NUM_PTR),
   localparam int GRP_SHIFT = $clog2(GROUP_SZ),
   localparam int WB_SEL_W  = SEL_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2:0]                mode_i,
   input  logic [OFS_W-1:0]          offset_i,
   input  logic [DADDR_W-1:0]        abs_addr_i,
   input  logic [PAGE_W-1:0]         dp_page_i,
   input  logic [OFS_W-1:0]          dp_i,
   input  logic [PAGE_W-1:0]         sp_page_i,
   input  logic [OFS_W-1:0]          sp_i,
   input  logic [OFS_W-1:0]          io_base_i,
   input  logic [PAGE_W-1:0]         ar_page_i,
   input  logic [NUM_PTR*OFS_W-1:0]  ar_i,
   input  logic [SEL_W-1:0]          ptr_sel_i,
   input  logic [PAGE_W-1:0]         coef_page_i,
   input  logic [OFS_W-1:0]          coef_ptr_i,
   input  logic                      post_inc_i,
   input  logic                      circ_en_i,
   input  logic [NGRP*OFS_W-1:0]     buf_start_i,
   input  logic [NGRP*OFS_W-1:0]     buf_size_i,
   input  logic [OFS_W-1:0]          coef_start_i,
   input  logic [OFS_W-1:0]          coef_size_i,
   output logic [DADDR_W-1:0]        addr_o,
   output logic [OFS_W-1:0]          io_addr_o,
   output logic                      io_sel_o,
   output logic                      wb_en_o,
   output logic [WB_SEL_W-1:0]       wb_sel_o,
   output logic [OFS_W-1:0]          wb_val_o
);
   // elaboration-time parameter checks
   if (NUM_PTR < 2 || (1 << SEL_W) != NUM_PTR) begin : g_bad_nptr
      $error("NUM_PTR must be a power of two of at least 2");
   end
   if (GROUP_SZ < 1 || (1 << GRP_SHIFT) != GROUP_SZ || GROUP_SZ > NUM_PTR) begin : g_bad_grp
      $error("GROUP_SZ must be a power of two not above NUM_PTR");
   end
   if (IO_LOW_W < 1 || IO_LOW_W >= OFS_W) begin : g_bad_io
      $error("IO_LOW_W must lie in 1..OFS_W-1");
   end

   // per-pointer unpacking
   logic [OFS_W-1:0] ar_arr [NUM_PTR];
   logic [OFS_W-1:0] bs_arr [NGRP];
   logic [OFS_W-1:0] bz_arr [NGRP];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PTR; gi++) begin : g_ar
         assign ar_arr[gi] = ar_i[gi*OFS_W +: OFS_W];
      end
      for (gi = 0; gi < NGRP; gi++) begin : g_buf
         assign bs_arr[gi] = buf_start_i[gi*OFS_W +: OFS_W];
         assign bz_arr[gi] = buf_size_i[gi*OFS_W +: OFS_W];
      end
   endgenerate

   // direct modes
   logic [DADDR_W-1:0] dir_addr;
   agu_direct #(
      .PAGE_W(PAGE_W), .OFS_W(OFS_W), .IO_LOW_W(IO_LOW_W)
   ) u_direct (
      .mode(mode_i), .offset(offset_i), .abs_addr(abs_addr_i),
      .dp_page(dp_page_i), .dp(dp_i), .sp_page(sp_page_i), .sp(sp_i),
      .io_base(io_base_i), .dir_addr(dir_addr), .io_addr(io_addr_o),
      .io_sel(io_sel_o)
   );

   // pointer selection and buffer group lookup
   logic                   is_coef;
   logic [OFS_W-1:0]       cur_ptr;
   logic [OFS_W-1:0]       cur_start;
   logic [OFS_W-1:0]       cur_size;
   logic [PAGE_W-1:0]      cur_page;
   logic [SEL_W-1:0]       grp_idx;
   logic [OFS_W-1:0]       nxt_ptr;

   assign is_coef = (mode_i == AM_COEF);
   assign grp_idx = ptr_sel_i >> GRP_SHIFT;

   always_comb begin
      if (is_coef) begin
         cur_ptr   = coef_ptr_i;
         cur_start = coef_start_i;
         cur_size  = coef_size_i;
         cur_page  = coef_page_i;
      end else begin
         cur_ptr   = ar_arr[ptr_sel_i];
         cur_start = bs_arr[grp_idx];
         cur_size  = bz_arr[grp_idx];
         cur_page  = ar_page_i;
      end
   end

   agu_ptr_step #(
      .OFS_W(OFS_W), .CIRC_SUPPORT(CIRC_SUPPORT)
   ) u_step (
      .ptr(cur_ptr), .start(cur_start), .size(cur_size),
      .circ_en(circ_en_i), .nxt(nxt_ptr)
   );

   // output address
   always_comb begin
      if (is_ptr_mode(mode_i))  addr_o = {cur_page, cur_ptr};
      else                      addr_o = dir_addr;
   end

   // registered write-back
   logic                upd_en;
   logic [WB_SEL_W-1:0] upd_sel;
   assign upd_en  = is_ptr_mode(mode_i) && post_inc_i;
   assign upd_sel = is_coef ? WB_SEL_W'(NUM_PTR) : WB_SEL_W'(ptr_sel_i);

   agu_wb_reg #(
      .SEL_W(WB_SEL_W), .OFS_W(OFS_W)
   ) u_wb (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_sel(upd_sel),
      .upd_val(nxt_ptr), .wb_en(wb_en_o), .wb_sel(wb_sel_o),
      .wb_val(wb_val_o)
   );
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
   parameter int PAGE_W   = 7,
   parameter int OFS_W    = 16,
   parameter int IO_LOW_W = 6,
   parameter int NUM_PTR  = 8,
   parameter int WB_SEL_W = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [2:0]                mode_i,
   input logic [OFS_W-1:0]          offset_i,
   input logic [PAGE_W+OFS_W-1:0]   abs_addr_i,
   input logic [PAGE_W-1:0]         dp_page_i,
   input logic [PAGE_W-1:0]         sp_page_i,
   input logic                      post_inc_i,
   input logic                      circ_en_i,
   input logic [PAGE_W+OFS_W-1:0]   addr_o,
   input logic [OFS_W-1:0]          io_addr_o,
   input logic                      io_sel_o,
   input logic                      wb_en_o,
   input logic [WB_SEL_W-1:0]       wb_sel_o,
   input logic [OFS_W-1:0]          wb_val_o
);
   assert_abs_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd0) |-> (addr_o == abs_addr_i));

   assert_page_no_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd1) |-> (addr_o[PAGE_W+OFS_W-1:OFS_W] == dp_page_i));

   assert_stack_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd2) |-> (addr_o[PAGE_W+OFS_W-1:OFS_W] == sp_page_i));

   assert_io_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd3) |-> (io_sel_o && addr_o == '0 &&
                            io_addr_o[IO_LOW_W-1:0] == offset_i[IO_LOW_W-1:0]));

   assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd4 && post_inc_i && !circ_en_i) |=>
         (wb_val_o == OFS_W'($past(addr_o[OFS_W-1:0]) + OFS_W'(1))));

   assert_wb_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == 3'd4 || mode_i == 3'd5) && post_inc_i) |=> wb_en_o);

   assert_wb_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !((mode_i == 3'd4 || mode_i == 3'd5) && post_inc_i) |=> !wb_en_o);

   assert_coef_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd5 && post_inc_i) |=> (wb_sel_o == WB_SEL_W'(NUM_PTR)));

   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |=> !wb_en_o);
endmodule

bind dsp_agu agu_checker #(
   .PAGE_W(PAGE_W), .OFS_W(OFS_W), .IO_LOW_W(IO_LOW_W),
   .NUM_PTR(NUM_PTR), .WB_SEL_W(WB_SEL_W)
) u_agu_checker (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .offset_i(offset_i),
   .abs_addr_i(abs_addr_i), .dp_page_i(dp_page_i), .sp_page_i(sp_page_i),
   .post_inc_i(post_inc_i), .circ_en_i(circ_en_i), .addr_o(addr_o),
   .io_addr_o(io_addr_o), .io_sel_o(io_sel_o), .wb_en_o(wb_en_o),
   .wb_sel_o(wb_sel_o), .wb_val_o(wb_val_o)
);

// File: tb/test_dsp_agu.sv
module test_dsp_agu;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   mode_i = 3'd0;
   logic [15:0]  offset_i = '0;
   logic [22:0]  abs_addr_i = '0;
   logic [6:0]   dp_page_i = '0, sp_page_i = '0, ar_page_i = '0, coef_page_i = '0;
   logic [15:0]  dp_i = '0, sp_i = '0, io_base_i = '0, coef_ptr_i = '0;
   logic [127:0] ar_i = '0;
   logic [2:0]   ptr_sel_i = '0;
   logic         post_inc_i = 1'b0, circ_en_i = 1'b0;
   logic [31:0]  buf_start_i = '0, buf_size_i = '0;
   logic [15:0]  coef_start_i = '0, coef_size_i = '0;
   logic [22:0]  addr_o;
   logic [15:0]  io_addr_o;
   logic         io_sel_o, wb_en_o;
   logic [3:0]   wb_sel_o;
   logic [15:0]  wb_val_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   dsp_agu i_dsp_agu (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .offset_i(offset_i),
      .abs_addr_i(abs_addr_i), .dp_page_i(dp_page_i), .dp_i(dp_i),
      .sp_page_i(sp_page_i), .sp_i(sp_i), .io_base_i(io_base_i),
      .ar_page_i(ar_page_i), .ar_i(ar_i), .ptr_sel_i(ptr_sel_i),
      .coef_page_i(coef_page_i), .coef_ptr_i(coef_ptr_i),
      .post_inc_i(post_inc_i), .circ_en_i(circ_en_i),
      .buf_start_i(buf_start_i), .buf_size_i(buf_size_i),
      .coef_start_i(coef_start_i), .coef_size_i(coef_size_i),
      .addr_o(addr_o), .io_addr_o(io_addr_o), .io_sel_o(io_sel_o),
      .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o), .wb_val_o(wb_val_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] val(input int k);
      logic [15:0] v;
      v = 16'(k * 16'h2E59);
      if (k % 3 == 1) v = 16'hFFFF - 16'(k);
      return v;
   endfunction

   function automatic logic [15:0] step_exp(input logic [15:0] p, input logic [15:0] s,
                                            input logic [15:0] z, input bit c);
      if (c && z != 16'd0 && p == 16'(s + z - 16'd1)) return s;
      return 16'(p + 16'd1);
   endfunction

   // pointer access: caller is at a negedge; returns at the next negedge
   task automatic ptr_op(input int sel, input bit coef, input logic [15:0] p,
                         input bit inc, input bit circ, output logic [15:0] nxt);
      logic [15:0] s, z;
      mode_i     = coef ? 3'd5 : 3'd4;
      ptr_sel_i  = 3'(sel);
      post_inc_i = inc;
      circ_en_i  = circ;
      if (coef) coef_ptr_i = p;
      else      ar_i[sel*16 +: 16] = p;
      if (coef) begin s = coef_start_i; z = coef_size_i; end
      else begin s = buf_start_i[(sel/4)*16 +: 16]; z = buf_size_i[(sel/4)*16 +: 16]; end
      nxt = step_exp(p, s, z, circ);
      #1;
      if (coef) chk("R6 coef addr", 32'(addr_o), 32'({coef_page_i, p}));
      else      chk("R5 ptr addr", 32'(addr_o), 32'({ar_page_i, p}));
      @(negedge clk);
      chk("R10 wb_en", 32'(wb_en_o), 32'(inc));
      if (inc) begin
         chk("R10 wb_sel", 32'(wb_sel_o), coef ? 32'd8 : 32'(sel));
         if (!circ)                chk("R7 linear step", 32'(wb_val_o), 32'(nxt));
         else if (z == 16'd0)      chk("R9 zero size", 32'(wb_val_o), 32'(nxt));
         else                      chk("R8 circular step", 32'(wb_val_o), 32'(nxt));
      end
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] p, n;
      for (int k = 0; k < 8; k++) ar_i[k*16 +: 16] = 16'(16'h0A00 + k * 16'h0111);
      ar_page_i = 7'h15; coef_page_i = 7'h6B; dp_page_i = 7'h33; sp_page_i = 7'h4C;
      buf_start_i = {16'h2000, 16'h0100};
      buf_size_i  = {16'd3, 16'd5};
      coef_start_i = 16'h0400; coef_size_i = 16'd4;
      // reset: request a write-back while reset is held
      mode_i = 3'd4; post_inc_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 reset wb_en", 32'(wb_en_o), 32'd0);
      rst_n = 1'b1;
      mode_i = 3'd0; post_inc_i = 1'b0;

      // R1 absolute and unused codes
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         mode_i = 3'd0; abs_addr_i = 23'(k * 23'h1A2B3C + 7);
         #1 chk("R1 absolute", 32'(addr_o), 32'(abs_addr_i));
         chk("R4 io_sel low", 32'(io_sel_o), 32'd0);
      end
      for (int m = 6; m < 8; m++) begin
         @(negedge clk);
         mode_i = 3'(m); post_inc_i = 1'b1;
         #1 chk("R1 unused mode addr", 32'(addr_o), 32'd0);
         @(negedge clk);
         chk("R1 unused mode no wb", 32'(wb_en_o), 32'd0);
         post_inc_i = 1'b0;
      end

      // R2 / R3 sweeps including carry out of the 16-bit sum
      for (int a = 0; a < 12; a++) begin
         for (int b = 0; b < 12; b++) begin
            @(negedge clk);
            dp_i = val(a); sp_i = val(a + 5); offset_i = val(b + 2);
            mode_i = 3'd1;
            #1 chk("R2 paged", 32'(addr_o), 32'({dp_page_i, 16'(dp_i + offset_i)}));
            mode_i = 3'd2;
            #1 chk("R3 stack", 32'(addr_o), 32'({sp_page_i, 16'(sp_i + offset_i)}));
         end
      end

      // R4 I/O: every 6-bit offset against several bases
      for (int bb = 0; bb < 4; bb++) begin
         for (int o = 0; o < 64; o++) begin
            @(negedge clk);
            mode_i = 3'd3; io_base_i = val(bb * 7 + 1);
            offset_i = 16'(16'hFFC0 ^ (bb * 16'h1000)) | 16'(o);
            #1 chk("R4 io addr", 32'(io_addr_o), 32'({io_base_i[15:6], 6'(o)}));
            chk("R4 io_sel", 32'(io_sel_o), 32'd1);
            chk("R4 data addr zero", 32'(addr_o), 32'd0);
         end
      end

      // R5/R7/R10: every pointer, linear, including 0xFFFF rollover
      @(negedge clk);
      for (int s = 0; s < 8; s++) begin
         ptr_op(s, 1'b0, 16'hFFFE, 1'b1, 1'b0, n);
         ptr_op(s, 1'b0, n, 1'b1, 1'b0, n);
         chk("R7 rollover", 32'(n), 32'd0);
         ptr_op(s, 1'b0, 16'(16'h1234 * s), 1'b0, 1'b0, n);
      end

      // R8: chained circular walks, back to back, every pointer and coef
      for (int s = 0; s < 8; s++) begin
         p = 16'(buf_start_i[(s/4)*16 +: 16] + 16'd1);
         for (int t = 0; t < 7; t++) ptr_op(s, 1'b0, p, 1'b1, 1'b1, p);
      end
      p = coef_start_i;
      for (int t = 0; t < 9; t++) ptr_op(0, 1'b1, p, 1'b1, 1'b1, p);
      ptr_op(0, 1'b1, 16'h0403, 1'b1, 1'b0, n);
      chk("R7 coef no circ", 32'(n), 32'h0404);

      // R9: size zero in group 1 disables wrap; group 0 still wraps
      buf_size_i = {16'd0, 16'd5};
      ptr_op(5, 1'b0, 16'h1FFF, 1'b1, 1'b1, n);
      chk("R9 no wrap value", 32'(n), 32'h2000);
      ptr_op(2, 1'b0, 16'h0104, 1'b1, 1'b1, n);
      chk("R8 group0 wrap", 32'(n), 32'h0100);
      // wrap across 0xFFFF boundary of the 16-bit space
      buf_size_i = {16'd4, 16'd5};
      buf_start_i = {16'hFFFE, 16'h0100};
      ptr_op(6, 1'b0, 16'hFFFF, 1'b1, 1'b1, n);
      ptr_op(6, 1'b0, n, 1'b1, 1'b1, n);
      ptr_op(6, 1'b0, n, 1'b1, 1'b1, n);
      chk("R8 wrap past top", 32'(n), 32'hFFFE);

      // R10: access without post-modify clears strobe
      ptr_op(3, 1'b0, 16'h0055, 1'b0, 1'b1, n);
      mode_i = 3'd0; post_inc_i = 1'b0;
      @(negedge clk);
      chk("R10 idle no wb", 32'(wb_en_o), 32'd0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule